// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This unit returns the smaller or the larger of two IEEE-754 operands, in single or double precision. A precision select chooses the width, and an op select chooses minimum or maximum. Each accepted operation gives its result one clock later, together with an output valid and an invalid-operation exception. A sticky status bit collects those exceptions until a clear input resets it.

The operands are ordered by sign and magnitude, so negative zero is strictly below positive zero. When only one operand is a NaN, the result is the other operand. When both operands are NaNs, the result is an all-ones default NaN. A signalling NaN anywhere in the pair raises the invalid exception. In single precision the data sits in the low 32 bits of each bus.

Top module: `fp_minmax`

## Requirements
- R1: After reset, out_valid, invalid and sticky_invalid are all 0.
- R2: out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1. In that cycle result and invalid hold the outcome of the operation accepted then. When in_valid was 0 in the previous cycle, out_valid and invalid are 0.
- R3: For two non-NaN operands (infinities included), op_max=0 returns the numerically smaller operand and op_max=1 returns the larger. This holds for mixed signs and for two negative operands. The invalid flag is 0.
- R4: Negative zero (only the sign bit set) orders below positive zero. Minimum of the pair returns negative zero and maximum returns positive zero, whichever operand position each zero is in.
- R5: A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the top fraction bit is 1 (bit 22 in single precision, bit 51 in double precision) and signalling otherwise. A quiet NaN paired with a non-NaN returns the non-NaN operand with invalid=0.
- R6: A signalling NaN paired with a non-NaN returns the non-NaN operand with invalid=1.
- R7: When both operands are NaNs, the result is the default NaN. That is 0xFFFFFFFFFFFFFFFF in double precision and 0x00000000FFFFFFFF in single precision. invalid is 1 if either NaN is signalling, 0 if both are quiet.
- R8: With dbl=0, only bits 31:0 of a and b are used, and bits 63:32 of the result are 0. With dbl=1, all 64 bits are used.
- R9: sticky_invalid becomes 1 in the cycle after a cycle with out_valid=1 and invalid=1, and then stays 1. A clear_sticky=1 makes it 0 in the next cycle, and the clear takes priority over a coinciding exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| op_max | input | 1 | 1 selects maximum, 0 minimum |
| dbl | input | 1 | 1 double precision, 0 single precision |
| clear_sticky | input | 1 | Clears the sticky invalid bit |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Selected operand or default NaN |
| invalid | output | 1 | Invalid-operation exception for this result |
| sticky_invalid | output | 1 | Accumulated invalid exceptions |

## Verification
A result, its valid and its invalid flag are due exactly one clock after the request, and the sticky bit follows one clock after that. The driver sets the inputs on the falling edge and pushes the expected result and flag into a queue. The monitor pops one item on each falling edge where out_valid is high, which is half a cycle after the capturing edge. A result that shows up a cycle late, or in a cycle with no request, therefore mismatches the queue order or finds the queue empty. The sticky bit is sampled two falling edges after the request, both before and after a clear.

// File: rtl/fp_minmax.sv
module fp_minmax #(
  parameter int DW   = 64,
  parameter int SW   = 32,
  parameter int DEXP = 11,
  parameter int SEXP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          op_max,
  input  logic          dbl,
  input  logic          clear_sticky,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          invalid,
  output logic          sticky_invalid
);
  localparam int DFR = DW - 1 - DEXP;
  localparam int SFR = SW - 1 - SEXP;

  function automatic logic [DW-1:0] canon(input logic [DW-1:0] x, input logic d);
    return d ? x : {{(DW-SW){1'b0}}, x[SW-1:0]};
  endfunction

  function automatic logic is_nan(input logic [DW-1:0] x, input logic d);
    return d ? (&x[DW-2:DFR] && |x[DFR-1:0]) : (&x[SW-2:SFR] && |x[SFR-1:0]);
  endfunction

  function automatic logic is_quiet(input logic [DW-1:0] x, input logic d);
    return d ? x[DFR-1] : x[SFR-1];
  endfunction

  logic [DW-1:0] ca, cb, pick, dnan, res_d;
  logic          sa, sb, na, nb, sna, snb, a_lt_b, b_lt_a, inv_d;

  assign ca   = canon(a, dbl);
  assign cb   = canon(b, dbl);
  assign sa   = dbl ? a[DW-1] : a[SW-1];
  assign sb   = dbl ? b[DW-1] : b[SW-1];
  assign na   = is_nan(a, dbl);
  assign nb   = is_nan(b, dbl);
  assign sna  = na && !is_quiet(a, dbl);
  assign snb  = nb && !is_quiet(b, dbl);
  assign dnan = canon('1, dbl);

  always_comb begin
    logic [DW-2:0] ma, mb;
    ma = dbl ? a[DW-2:0] : {{(DW-SW){1'b0}}, a[SW-2:0]};
    mb = dbl ? b[DW-2:0] : {{(DW-SW){1'b0}}, b[SW-2:0]};
    if (sa != sb) begin
      a_lt_b = sa;
      b_lt_a = sb;
    end else if (sa) begin
      a_lt_b = ma > mb;
      b_lt_a = mb > ma;
    end else begin
      a_lt_b = ma < mb;
      b_lt_a = mb < ma;
    end
  end

  assign pick  = op_max ? (b_lt_a ? ca : cb) : (a_lt_b ? ca : cb);
  assign res_d = (na && nb) ? dnan : na ? cb : nb ? ca : pick;
  assign inv_d = sna || snb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      invalid        <= 1'b0;
      result         <= '0;
      sticky_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      invalid   <= in_valid && inv_d;
      if (in_valid) result <= res_d;
      if (clear_sticky) sticky_invalid <= 1'b0;
      else if (out_valid && invalid) sticky_invalid <= 1'b1;
    end
  end
endmodule

module fp_minmax_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] a,
  input logic [63:0] b,
  input logic        dbl,
  input logic        clear_sticky,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        invalid,
  input logic        sticky_invalid
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !invalid);
  a_r8_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dbl |=> result[63:32] == 32'h0);
  a_r3_equal_operands: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dbl && a == b && a[62:52] != 11'h7ff |=> result == $past(a) && !invalid);
  a_r9_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && invalid && !clear_sticky |=> sticky_invalid);
  a_r9_sticky_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clear_sticky |=> !sticky_invalid);
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_invalid && !clear_sticky |=> sticky_invalid);
endmodule

bind fp_minmax fp_minmax_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .dbl(dbl),
  .clear_sticky(clear_sticky), .out_valid(out_valid), .result(result),
  .invalid(invalid), .sticky_invalid(sticky_invalid)
);

// File: tb/sim_fp_minmax.sv
module sim_fp_minmax;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, op_max = 1'b0, dbl = 1'b0, clear_sticky = 1'b0;
  logic [63:0] a = '0, b = '0, result;
  logic out_valid, invalid, sticky_invalid;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] q_res[$];
  logic        q_inv[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_minmax u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .op_max(op_max),
    .dbl(dbl), .clear_sticky(clear_sticky), .out_valid(out_valid), .result(result),
    .invalid(invalid), .sticky_invalid(sticky_invalid)
  );

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [63:0] xa, logic [63:0] xb, logic mx, logic d,
                       logic [63:0] er, logic ei);
    @(negedge clk);
    a = xa; b = xb; op_max = mx; dbl = d; in_valid = 1'b1;
    q_res.push_back(er); q_inv.push_back(ei); q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_res.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected result actual %h expected none", result);
      end else begin
        logic [63:0] er; logic ei; string t;
        er = q_res.pop_front(); ei = q_inv.pop_front(); t = q_tag.pop_front();
        if (result !== er || invalid !== ei) begin
          errors++;
          $display("FAIL %s actual %h/%0b expected %h/%0b", t, result, invalid, er, ei);
        end
      end
    end
  end

  localparam logic [63:0] S1 = 64'h3f800000, S2 = 64'h40000000, SM1 = 64'hbf800000,
    SM2 = 64'hc0000000, SMH = 64'hbf000000, SZ = 64'h0, SNZ = 64'h80000000,
    SQ = 64'h7fc00000, SQN = 64'hffc00000, SS = 64'h7fa00000, SSN = 64'hffb00000,
    SDN = 64'h00000000ffffffff, SINF = 64'h7f800000;
  localparam logic [63:0] D1 = 64'h3ff0000000000000, D2 = 64'h4000000000000000,
    DM1 = 64'hbff0000000000000, DM2 = 64'hc000000000000000, DZ = 64'h0,
    DNZ = 64'h8000000000000000, DQ = 64'h7ff8000000000000, DS = 64'h7ff4000000000000,
    DDN = 64'hffffffffffffffff;

  initial begin
    repeat (3) @(negedge clk);
    check1("R1 out_valid", out_valid, 1'b0);
    check1("R1 invalid", invalid, 1'b0);
    check1("R1 sticky", sticky_invalid, 1'b0);
    rst_n = 1'b1;
    idle(2);
    check1("R2 idle out_valid", out_valid, 1'b0);

    drive("R3 sp max 1 vs -0.5", S1, SMH, 1, 0, S1, 0);
    drive("R3 sp min 1 vs -0.5", S1, SMH, 0, 0, SMH, 0);
    drive("R3 sp min -1 vs -2", SM1, SM2, 0, 0, SM2, 0);
    drive("R3 sp max -1 vs -2", SM1, SM2, 1, 0, SM1, 0);
    drive("R3 sp min 2 vs 1", S2, S1, 0, 0, S1, 0);
    drive("R3 sp max inf vs 2", S2, SINF, 1, 0, SINF, 0);
    drive("R3 dp min 1 vs -2", D1, DM2, 0, 1, DM2, 0);
    drive("R3 dp max -1 vs -2", DM1, DM2, 1, 1, DM1, 0);
    drive("R3 dp max 1 vs 2", D1, D2, 1, 1, D2, 0);
    idle(1);
    drive("R4 sp min +0,-0", SZ, SNZ, 0, 0, SNZ, 0);
    drive("R4 sp min -0,+0", SNZ, SZ, 0, 0, SNZ, 0);
    drive("R4 sp max +0,-0", SZ, SNZ, 1, 0, SZ, 0);
    drive("R4 sp max -0,+0", SNZ, SZ, 1, 0, SZ, 0);
    drive("R4 dp min +0,-0", DZ, DNZ, 0, 1, DNZ, 0);
    drive("R4 dp max -0,+0", DNZ, DZ, 1, 1, DZ, 0);
    drive("R5 sp min qnan,1", SQ, S1, 0, 0, S1, 0);
    drive("R5 sp max 1,-qnan", S1, SQN, 1, 0, S1, 0);
    drive("R5 dp min -2,qnan", DM2, DQ, 0, 1, DM2, 0);
    idle(3);
    check1("R5 sticky untouched by qnan", sticky_invalid, 1'b0);

    drive("R7 sp both qnan", SQ, SQN, 0, 0, SDN, 0);
    drive("R7 dp both qnan", DQ, DQ, 1, 1, DDN, 0);
    idle(3);
    check1("R7 sticky after quiet pair", sticky_invalid, 1'b0);

    drive("R6 sp max 1,snan", S1, SS, 1, 0, S1, 1);
    idle(1);
    @(negedge clk);
    check1("R9 sticky set", sticky_invalid, 1'b1);
    drive("R6 sp min -snan,-1", SSN, SM1, 0, 0, SM1, 1);
    drive("R6 dp max snan,-1", DS, DM1, 1, 1, DM1, 1);
    drive("R7 sp snan,qnan", SSN, SQ, 0, 0, SDN, 1);
    drive("R7 sp qnan,snan", SQ, SS, 1, 0, SDN, 1);
    drive("R7 dp snan,qnan", DS, DQ, 0, 1, DDN, 1);
    drive("R7 dp both snan", DS, DS, 1, 1, DDN, 1);
    drive("R8 sp upper ignored", 64'hdeadbeef_3f800000, 64'h12345678_bf800000, 0, 0, SM1, 0);
    drive("R8 dp full width", 64'h00000000_3f800000, 64'h12345678_00000000, 1, 1, 64'h12345678_00000000, 0);
    drive("R8 sp nan from upper not seen", 64'hfff80000_3f800000, S2, 1, 0, S2, 0);
    idle(3);
    check1("R9 sticky held", sticky_invalid, 1'b1);

    @(negedge clk); clear_sticky = 1'b1;
    @(negedge clk); clear_sticky = 1'b0;
    check1("R9 sticky cleared", sticky_invalid, 1'b0);

    drive("R9 snan for clear race", SS, S1, 0, 0, S1, 1);
    @(negedge clk); in_valid = 1'b0; clear_sticky = 1'b1;
    @(negedge clk); clear_sticky = 1'b0;
    check1("R9 clear wins over exception", sticky_invalid, 1'b0);
    idle(2);
    check1("R9 stays clear", sticky_invalid, 1'b0);
    check1("R2 drained", q_res.size() == 0, 1'b1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule